// File: doc/BRIEF.md
# Double-Buffered Compare Timer

This block is one timer channel built around a 16-bit up-counter. The counter advances on a count tick. The tick comes from a small prescaler that fires every 1, 4 or 16 system clocks, or from an external pin. The pin passes through a two-flop synchronizer, and each rising edge on it gives one tick. A run bit starts the counter. Clearing the run bit stops the counter and forces it to zero. In clear-on-match mode the counter returns to zero on the tick that finds it equal to compare register B. Otherwise it runs freely and wraps.

Two compare registers, A and B, each drive a single-cycle match pulse. Each register has a write buffer behind it. When buffering is switched on and the counter is running, software writes land only in the buffers. Both active registers then reload together on the tick that matches B, so a new period and duty value change at a clean period boundary. While the counter is stopped, or when buffering is off, a write reaches the active register at once. A one-cycle overflow pulse marks each wrap from 0xFFFF to 0x0000.

A plain write port programs the block: a write enable, a 2-bit address and a data word.

Top module: `dbuf_cmp_timer`

## Requirements
- R1: While the run bit is 1, each count tick increments `count_o` by one, modulo 2^16. The run bit is bit 0 of the control register, at address 0.
- R2: The control field bits [4:3] select the tick source. Code 0 gives a tick every clock. Code 1 gives a tick on every 4th clock and code 2 on every 16th clock, both counted from a free-running divider that starts at reset. Code 3 gives a tick on each rising edge of `ext_i`, taken after a two-flop synchronizer.
- R3: While the run bit is 0, the counter holds zero. It clears on the first clock edge after the run bit is written 0.
- R4: When the clear-enable bit (control bit 1) is 1, a tick that finds the counter equal to compare register B loads zero instead of incrementing.
- R5: `ovf_o` pulses for one cycle when a tick wraps the counter from 0xFFFF to 0x0000 by incrementing. No pulse occurs when the counter is cleared by a match.
- R6: `match_a_o` pulses for one cycle, aligned with the counter update, for each running tick on which the counter equals compare register A (address 1).
- R7: `match_b_o` behaves the same way for compare register B (address 2).
- R8: With the buffer-enable bit (control bit 2) at 1 and the counter running, writes to addresses 1 and 2 fill only the buffers. Both active registers load from their buffers on a tick that matches register B.
- R9: With buffering disabled, or while the counter is stopped, a compare write takes effect in the active register on the clock edge of the write.
- R10: After a synchronous reset, all of the following are zero: the counter, the control bits, both compare registers, both buffers and every pulse output.
- R11: A write to address 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 compare A, 2 compare B |
| wr_data | input | 16 | Write data |
| ext_i | input | 1 | External count input, asynchronous |
| count_o | output | 16 | Current counter value |
| match_a_o | output | 1 | Compare A match pulse |
| match_b_o | output | 1 | Compare B match pulse |
| ovf_o | output | 1 | Overflow pulse |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:

- **Buffered write while running.** A design that let the write through at once would shorten the current period instead of changing it at the next B match.
- **Compare writes while stopped with buffering on.** A design that still held these in the buffer would keep the old match points after restart.
- **Clear-on-match with compare B at zero.** This should give a match on every tick. An off-by-one clear would let the counter escape to one.
- **Full free-running wrap.** A wrong overflow condition would either miss the pulse or raise it on clear-on-match reloads.
- **Slow taps and the synchronized external edge.** A wrong divider phase, or edge detection on the raw pin, would shift every count by a cycle.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  typedef enum logic [1:0] {
    SRC_DIV1  = 2'd0,
    SRC_DIV4  = 2'd1,
    SRC_DIV16 = 2'd2,
    SRC_EXT   = 2'd3
  } tick_src_e;

  // control word layout, MSB first: [4:3] source, [2] buffer enable,
  // [1] clear on B, [0] run
  typedef struct packed {
    tick_src_e src;
    logic      dbuf;
    logic      clr_en;
    logic      run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CMPA = 2'd1;
  localparam logic [1:0] ADDR_CMPB = 2'd2;

endpackage

// File: rtl/cmp_tick_gen.sv
module cmp_tick_gen
  import cmp_timer_pkg::*;
#(
  parameter int MID_LOG2    = 2,
  parameter int SLOW_LOG2   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  tick_src_e src,
  input  logic      ext_i,
  output logic      tick_o
);

  logic [SLOW_LOG2-1:0] div_q;
  logic [SYNC_STAGES:0] sync_q;
  logic                 ext_edge;
  logic                 tap_mid;
  logic                 tap_slow;

  // free-running divider shared by the two slow taps
  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  // synchronizer chain plus one history flop for edge detection
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-1:0], ext_i};
  end

  assign ext_edge = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign tap_mid  = &div_q[MID_LOG2-1:0];
  assign tap_slow = &div_q;

  always_comb begin
    unique case (src)
      SRC_DIV1:  tick_o = 1'b1;
      SRC_DIV4:  tick_o = tap_mid;
      SRC_DIV16: tick_o = tap_slow;
      default:   tick_o = ext_edge;
    endcase
  end

endmodule

// File: rtl/cmp_bank.sv
module cmp_bank #(
  parameter int W     = 16,
  parameter int N_CMP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CMP-1:0] wr_sel,
  input  logic [W-1:0]     wr_data,
  input  logic             direct,
  input  logic             xfer,
  output logic [W-1:0]     cmp_o [N_CMP]
);

  logic [W-1:0] buf_q [N_CMP];
  logic [W-1:0] act_q [N_CMP];

  for (genvar g = 0; g < N_CMP; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        buf_q[g] <= '0;
        act_q[g] <= '0;
      end else begin
        if (wr_sel[g]) buf_q[g] <= wr_data;
        if (wr_sel[g] && direct) act_q[g] <= wr_data;
        else if (xfer)           act_q[g] <= buf_q[g];
      end
    end
    assign cmp_o[g] = act_q[g];
  end

endmodule

// File: rtl/cmp_count_core.sv
module cmp_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic         clr_en,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  output logic         hit_b,
  output logic [W-1:0] count_o,
  output logic         match_a_o,
  output logic         match_b_o,
  output logic         ovf_o
);

  localparam logic [W-1:0] ALL_ONES = '1;

  logic [W-1:0] cnt_q;
  logic         step;
  logic         hit_a;
  logic         reload;
  logic         wrap;

  assign step   = run & tick;
  assign hit_a  = step & (cnt_q == cmp_a);
  assign hit_b  = step & (cnt_q == cmp_b);
  assign reload = hit_b & clr_en;
  assign wrap   = step & (cnt_q == ALL_ONES) & ~reload;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      match_a_o <= 1'b0;
      match_b_o <= 1'b0;
      ovf_o     <= 1'b0;
    end else begin
      match_a_o <= hit_a;
      match_b_o <= hit_b;
      ovf_o     <= wrap;
      if (!run)        cnt_q <= '0;
      else if (reload) cnt_q <= '0;
      else if (step)   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/dbuf_cmp_timer.sv
module dbuf_cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int W           = 16,
  parameter int MID_LOG2    = 2,
  parameter int SLOW_LOG2   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         ext_i,
  output logic [W-1:0] count_o,
  output logic         match_a_o,
  output logic         match_b_o,
  output logic         ovf_o
);

  localparam int N_CMP = 2;

  ctrl_t            ctrl_q;
  logic             run_q;
  logic             clr_q;
  logic             tick;
  logic             hit_b;
  logic             direct;
  logic             xfer;
  logic [N_CMP-1:0] wr_sel;
  logic [W-1:0]     cmp_val [N_CMP];

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_en && wr_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  assign run_q     = ctrl_q.run;
  assign clr_q     = ctrl_q.clr_en;
  assign wr_sel[0] = wr_en && (wr_addr == ADDR_CMPA);
  assign wr_sel[1] = wr_en && (wr_addr == ADDR_CMPB);
  assign direct    = ~ctrl_q.dbuf | ~ctrl_q.run;
  assign xfer      = ctrl_q.dbuf & hit_b;

  cmp_tick_gen #(
    .MID_LOG2(MID_LOG2), .SLOW_LOG2(SLOW_LOG2), .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk(clk), .rst(rst), .src(ctrl_q.src), .ext_i(ext_i), .tick_o(tick)
  );

  cmp_bank #(.W(W), .N_CMP(N_CMP)) u_bank (
    .clk(clk), .rst(rst), .wr_sel(wr_sel), .wr_data(wr_data),
    .direct(direct), .xfer(xfer), .cmp_o(cmp_val)
  );

  cmp_count_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .run(run_q), .tick(tick), .clr_en(clr_q),
    .cmp_a(cmp_val[0]), .cmp_b(cmp_val[1]), .hit_b(hit_b),
    .count_o(count_o), .match_a_o(match_a_o), .match_b_o(match_b_o),
    .ovf_o(ovf_o)
  );

endmodule

// File: rtl/dbuf_cmp_timer_chk.sv
module dbuf_cmp_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         run_q,
  input logic         clr_en_q,
  input logic [W-1:0] count_o,
  input logic         match_a_o,
  input logic         match_b_o,
  input logic         ovf_o
);

  localparam logic [W-1:0] ALL_ONES = '1;

  p_stop_clears_r3: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> (count_o == '0));

  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(run_q) && (count_o != $past(count_o)) && !match_b_o)
      |-> (count_o == W'($past(count_o) + 1'b1)));

  p_clear_on_b_r4: assert property (@(posedge clk) disable iff (rst)
    (match_b_o && $past(clr_en_q)) |-> (count_o == '0));

  p_ovf_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> ((count_o == '0) && ($past(count_o) == ALL_ONES)));

  p_match_running_r6: assert property (@(posedge clk) disable iff (rst)
    (match_a_o || match_b_o) |-> $past(run_q));

endmodule

bind dbuf_cmp_timer dbuf_cmp_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .run_q(run_q), .clr_en_q(clr_q),
  .count_o(count_o), .match_a_o(match_a_o), .match_b_o(match_b_o),
  .ovf_o(ovf_o)
);

// File: tb/dbuf_cmp_timer_tb.sv
module dbuf_cmp_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        ext_i = 1'b0;
  logic [15:0] count_o;
  logic        match_a_o, match_b_o, ovf_o;

  int checks = 0;
  int errors = 0;
  int ovf_seen = 0;
  int ma_seen = 0;
  int mb_seen = 0;
  string cur_req = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  dbuf_cmp_timer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_i(ext_i), .count_o(count_o), .match_a_o(match_a_o),
    .match_b_o(match_b_o), .ovf_o(ovf_o)
  );

  // behavioural reference model
  bit        m_run, m_clr, m_dbuf;
  int        m_src;
  int        m_div;
  bit        m_s1, m_s2, m_s3;
  int        m_cnt;
  int        m_ca, m_cb, m_ba, m_bb;
  bit        m_ma, m_mb, m_ov;

  always @(posedge clk) begin
    bit tk, st, ha, hb, ld, direct;
    if (rst) begin
      m_run = 0; m_clr = 0; m_dbuf = 0; m_src = 0; m_div = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0;
      m_ca = 0; m_cb = 0; m_ba = 0; m_bb = 0;
      m_ma = 0; m_mb = 0; m_ov = 0;
    end else begin
      case (m_src)
        0: tk = 1;
        1: tk = (m_div % 4) == 3;
        2: tk = (m_div == 15);
        default: tk = m_s2 && !m_s3;
      endcase
      st = m_run && tk;
      ha = st && (m_cnt == m_ca);
      hb = st && (m_cnt == m_cb);
      ld = hb && m_clr;
      m_ma = ha; m_mb = hb;
      m_ov = st && (m_cnt == 65535) && !ld;
      direct = !m_dbuf || !m_run;
      if (m_dbuf && hb && !direct) begin
        m_ca = m_ba; m_cb = m_bb;
      end
      if (wr_en && wr_addr == 2'd1) begin
        m_ba = wr_data; if (direct) m_ca = wr_data;
      end
      if (wr_en && wr_addr == 2'd2) begin
        m_bb = wr_data; if (direct) m_cb = wr_data;
      end
      if (!m_run) m_cnt = 0;
      else if (ld) m_cnt = 0;
      else if (st) m_cnt = (m_cnt + 1) % 65536;
      if (wr_en && wr_addr == 2'd0) begin
        m_run = wr_data[0]; m_clr = wr_data[1]; m_dbuf = wr_data[2];
        m_src = int'(wr_data[4:3]);
      end
      m_div = (m_div + 1) % 16;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_i;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check({cur_req, "/R1"}, "count_o", int'(count_o), m_cnt);
      check({cur_req, "/R6"}, "match_a_o", int'(match_a_o), int'(m_ma));
      check({cur_req, "/R7"}, "match_b_o", int'(match_b_o), int'(m_mb));
      check({cur_req, "/R5"}, "ovf_o", int'(ovf_o), int'(m_ov));
      if (ovf_o) ovf_seen++;
      if (match_a_o) ma_seen++;
      if (match_b_o) mb_seen++;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] ctl(input bit run, input bit clr, input bit dbuf, input int src);
    return {11'd0, 2'(src), dbuf, clr, run};
  endfunction

  initial begin
    #(CLK_PERIOD * MAX_CYCLES);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check("R10", "count_o after reset", int'(count_o), 0);
    check("R10", "pulses after reset", int'({match_a_o, match_b_o, ovf_o}), 0);

    // R9: direct compare writes while stopped
    cur_req = "R9";
    wr(2'd1, 16'd5);
    wr(2'd2, 16'd9);
    // R4: clear on B, every-clock ticks
    cur_req = "R4";
    wr(2'd0, ctl(1, 1, 0, 0));
    idle(40);
    check("R4", "match B seen in clear mode", int'(mb_seen > 0), 1);

    // R2: slow taps
    cur_req = "R2";
    wr(2'd0, ctl(1, 1, 0, 1));
    idle(120);
    wr(2'd0, ctl(1, 1, 0, 2));
    idle(400);

    // R8: buffered writes while running
    cur_req = "R8";
    wr(2'd0, ctl(1, 1, 1, 0));
    ma_seen = 0;
    wr(2'd2, 16'd20);
    wr(2'd1, 16'd15);
    idle(80);
    check("R8", "match A after buffered reload", int'(ma_seen > 0), 1);

    // R3: stop clears the counter
    cur_req = "R3";
    wr(2'd0, ctl(0, 1, 1, 0));
    idle(2);
    check("R3", "count_o after stop", int'(count_o), 0);
    // R9: stopped with buffering on, writes go straight through
    cur_req = "R9";
    wr(2'd2, 16'd6);
    wr(2'd1, 16'd3);
    wr(2'd0, ctl(1, 1, 1, 0));
    idle(30);

    // R11: address 3 ignored
    cur_req = "R11";
    wr(2'd3, 16'h0000);
    idle(30);
    check("R11", "still running after addr 3 write", int'(count_o != 0 || match_b_o), 1);

    // R4 corner: compare B at zero
    cur_req = "R4";
    wr(2'd0, ctl(0, 1, 0, 0));
    wr(2'd2, 16'd0);
    wr(2'd0, ctl(1, 1, 0, 0));
    idle(20);
    check("R4", "count stays 0 with B=0", int'(count_o), 0);

    // R5: full free-running wrap
    cur_req = "R5";
    wr(2'd0, ctl(0, 0, 0, 0));
    wr(2'd1, 16'd100);
    wr(2'd2, 16'd200);
    ovf_seen = 0;
    wr(2'd0, ctl(1, 0, 0, 0));
    idle(65536 + 40);
    check("R5", "overflow pulses in one wrap", ovf_seen, 1);

    // R2: external input
    cur_req = "R2";
    wr(2'd0, ctl(0, 0, 0, 3));
    wr(2'd0, ctl(1, 0, 0, 3));
    for (int i = 0; i < 12; i++) begin
      ext_i = 1'b1; idle(3);
      ext_i = 1'b0; idle(3);
    end
    idle(4);
    check("R2", "external edges counted", int'(count_o), 12);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule